// File: doc/BRIEF.md
# Vector floating-point precision converter

This unit changes the precision of floating-point lanes held in a 128-bit vector. It supports four operations. Packed widening turns two single-precision lanes into two double-precision lanes. Packed narrowing does the reverse. The two scalar forms convert only the lowest lane.

Every operation takes a source vector, the previous destination value and a two-bit rounding mode. The scalar operations merge their single result lane into the previous destination value.

The conversion logic is combinational. Its result and four sticky-free exception flags are captured in one register stage when a valid strobe is high. They appear at the outputs on the following cycle, together with an output valid.

The unit handles normal numbers, subnormals, zeros, infinities and NaNs in both directions. It raises inexact, overflow, underflow and invalid, ORed across the lanes that an operation actually converts.

Top module: `fp_prec_conv`

## Requirements
- R1: With `op` = 2'b00 (packed widen), source bits [31:0] and [63:32] are each converted to a double, placed in result bits [63:0] and [127:64] respectively.
- R2: With `op` = 2'b01 (packed narrow), source bits [63:0] and [127:64] are each converted to a single, placed in result bits [31:0] and [63:32] respectively, and result bits [127:64] are zero.
- R3: With `op` = 2'b10 (scalar widen), the single in source bits [31:0] becomes a double in result bits [63:0], and result bits [127:64] equal the old destination bits [127:64].
- R4: With `op` = 2'b11 (scalar narrow), the double in source bits [63:0] becomes a single in result bits [31:0], and result bits [127:32] equal the old destination bits [127:32].
- R5: Inexact narrowing rounds according to `rmode`: 2'b00 to nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero. Any inexact lane sets `flg_inexact`.
- R6: Widening is exact and never raises inexact, overflow or underflow. Single subnormals become normal doubles of the same value.
- R7: A NaN input yields a NaN of the same sign. It has an all-ones exponent, a set top fraction bit, and the remaining top fraction bits copied from the input. An input NaN whose top fraction bit is clear (signalling) raises `flg_invalid`.
- R8: A narrowed magnitude that rounds beyond the largest finite single gives infinity when the rounding direction points away from zero (nearest; minus for negative; plus for positive). Otherwise it gives the largest finite single of that sign. It sets both `flg_overflow` and `flg_inexact`.
- R9: A narrowed magnitude below 2^-126 before rounding produces a subnormal single or zero, rounded per R5. `flg_underflow` is set exactly when such a result is also inexact.
- R10: Flags are the OR over the lanes the operation converts. The scalar operations ignore the upper source lanes.
- R11: After reset, outputs are zero and `out_valid` is low. When `in_valid` is high, result and flags update on the next rising edge and `out_valid` is high for that one cycle. Otherwise result and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for a conversion |
| op | input | 2 | Operation select (see R1 to R4) |
| rmode | input | 2 | Rounding mode for narrowing (see R5) |
| src | input | 128 | Source vector |
| old_dst | input | 128 | Previous destination value used for merging |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 128 | Converted vector |
| flg_inexact | output | 1 | Some converted lane was rounded |
| flg_overflow | output | 1 | Some narrowed lane overflowed |
| flg_underflow | output | 1 | Some narrowed lane was tiny and inexact |
| flg_invalid | output | 1 | Some converted lane was a signalling NaN |

## Verification
A fault in the rounding increment or the subnormal shift alignment shows in the low fraction bits of the converted lane. It also shows in the inexact or underflow flag on the cycle right after the strobe.

A mistake in lane steering shows as wrong merged or zeroed upper bits in that same cycle. This is because no state survives between conversions other than the output register.

The bench compares every lane against values it derives from real-number arithmetic and a search over single-precision encodings. It sweeps the guard, lowest kept and sticky bits in all four modes, at exponents around the overflow and subnormal boundaries, and follows with mixed random vectors.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_PK_WIDEN  = 2'b00,
    OP_PK_NARROW = 2'b01,
    OP_SC_WIDEN  = 2'b10,
    OP_SC_NARROW = 2'b11
  } cvt_op_e;

  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_DOWN = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;

  // single layout
  localparam int SP_EXP_BIAS = 127;
  localparam int DP_EXP_BIAS = 1023;
  localparam int BIAS_GAP    = DP_EXP_BIAS - SP_EXP_BIAS;   // 896

  typedef struct packed {
    logic nv;
    logic of;
    logic uf;
    logic nx;
  } fflags_t;

  typedef struct packed {
    logic [63:0] bits;
    fflags_t     fl;
  } wide_res_t;

  typedef struct packed {
    logic [31:0] bits;
    fflags_t     fl;
  } narrow_res_t;

  // single -> double, always exact
  function automatic wide_res_t fpc_widen(input logic [31:0] x);
    wide_res_t   r;
    logic [7:0]  ex;
    logic [22:0] fr;
    logic [22:0] m;
    int          p;
    ex = x[30:23];
    fr = x[22:0];
    r  = '0;
    r.bits[63] = x[31];
    p  = 0;
    m  = '0;
    if (ex == 8'hFF) begin
      r.bits[62:52] = '1;
      if (fr != '0) begin
        r.bits[51]    = 1'b1;
        r.bits[50:29] = fr[21:0];
        r.fl.nv       = !fr[22];
      end
    end else if (ex == 8'h00) begin
      if (fr != '0) begin
        for (int i = 0; i < 23; i++) if (fr[i]) p = i;
        m = fr << (23 - p);            // leading one falls off the top
        r.bits[62:52] = 11'(p + DP_EXP_BIAS - 149);
        r.bits[51:29] = m;
      end
    end else begin
      r.bits[62:52] = 11'(int'(ex) + BIAS_GAP);
      r.bits[51:29] = fr;
    end
    return r;
  endfunction

  // double -> single with directed rounding
  function automatic narrow_res_t fpc_narrow(input logic [63:0] d, input logic [1:0] rm);
    narrow_res_t r;
    logic        s;
    logic [10:0] ex;
    logic [51:0] fr;
    logic [52:0] man;
    logic [86:0] sh;
    logic [23:0] kept;
    logic [24:0] rnd;
    logic        g, st, inc, to_inf;
    int          eb, ki, eo;
    s  = d[63];
    ex = d[62:52];
    fr = d[51:0];
    r  = '0;
    r.bits[31] = s;
    to_inf = (rm == RM_NEAR) || (rm == RM_DOWN && s) || (rm == RM_UP && !s);
    inc = 1'b0;
    if (ex == 11'h7FF) begin
      r.bits[30:23] = '1;
      if (fr != '0) begin
        r.bits[22]   = 1'b1;
        r.bits[21:0] = fr[50:29];
        r.fl.nv      = !fr[51];
      end
    end else if (ex != '0 || fr != '0) begin
      man = {ex != '0, fr};
      eb  = int'(ex) - BIAS_GAP;
      if (ex == '0) eb = 1 - BIAS_GAP;
      if (eb >= 255) begin
        r.fl.of = 1'b1;
        r.fl.nx = 1'b1;
        r.bits[30:0] = to_inf ? {8'hFF, 23'h0} : {8'hFE, 23'h7FFFFF};
      end else begin
        ki = (eb < 1) ? 30 - eb : 29;
        if (ki > 60) ki = 60;
        sh   = 87'({man, 63'b0} >> ki);
        kept = sh[86:63];
        g    = sh[62];
        st   = |sh[61:0];
        r.fl.nx = g | st;
        case (rm)
          RM_NEAR: inc = g & (st | kept[0]);
          RM_DOWN: inc = s & (g | st);
          RM_UP:   inc = !s & (g | st);
          default: inc = 1'b0;
        endcase
        rnd = {1'b0, kept} + 25'(inc);
        if (eb < 1) begin
          r.bits[30:0] = {7'b0, rnd[23:0]};
          r.fl.uf      = r.fl.nx;
        end else begin
          eo = rnd[24] ? eb + 1 : eb;
          if (eo >= 255) begin
            r.fl.of = 1'b1;
            r.bits[30:0] = to_inf ? {8'hFF, 23'h0} : {8'hFE, 23'h7FFFFF};
          end else begin
            r.bits[30:0] = {8'(eo), rnd[24] ? 23'h0 : rnd[22:0]};
          end
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/fpc_widen_lane.sv
module fpc_widen_lane
  import fpc_pkg::*;
(
  input  logic [31:0] sp_in,
  output logic [63:0] dp_out,
  output fflags_t     fl
);
  wide_res_t w;
  assign w      = fpc_widen(sp_in);
  assign dp_out = w.bits;
  assign fl     = w.fl;
endmodule

// File: rtl/fpc_narrow_lane.sv
module fpc_narrow_lane
  import fpc_pkg::*;
(
  input  logic [63:0] dp_in,
  input  logic [1:0]  rm,
  output logic [31:0] sp_out,
  output fflags_t     fl
);
  narrow_res_t n;
  assign n      = fpc_narrow(dp_in, rm);
  assign sp_out = n.bits;
  assign fl     = n.fl;
endmodule

// File: rtl/fp_prec_conv.sv
module fp_prec_conv
  import fpc_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [1:0]       rmode,
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] old_dst,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             flg_inexact,
  output logic             flg_overflow,
  output logic             flg_underflow,
  output logic             flg_invalid
);
  localparam int LANES = VEC_W / 64;
  localparam int HALF  = VEC_W / 2;

  cvt_op_e          op_e;
  logic [63:0]      wid_bits [LANES];
  fflags_t          wid_fl   [LANES];
  logic [31:0]      nar_bits [LANES];
  fflags_t          nar_fl   [LANES];
  logic [VEC_W-1:0] nxt_res;
  fflags_t          nxt_fl;
  fflags_t          fl_q;
  logic             is_narrow;

  assign op_e      = cvt_op_e'(op);
  assign is_narrow = (op_e == OP_PK_NARROW) || (op_e == OP_SC_NARROW);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fpc_widen_lane u_wid (
      .sp_in (src[32*i +: 32]),
      .dp_out(wid_bits[i]),
      .fl    (wid_fl[i])
    );
    fpc_narrow_lane u_nar (
      .dp_in (src[64*i +: 64]),
      .rm    (rmode),
      .sp_out(nar_bits[i]),
      .fl    (nar_fl[i])
    );
  end

  // lane steering and merging
  always_comb begin
    nxt_res = old_dst;
    nxt_fl  = '0;
    case (op_e)
      OP_PK_WIDEN: begin
        for (int i = 0; i < LANES; i++) begin
          nxt_res[64*i +: 64] = wid_bits[i];
          nxt_fl = fflags_t'(nxt_fl | wid_fl[i]);
        end
      end
      OP_PK_NARROW: begin
        nxt_res = '0;
        for (int i = 0; i < LANES; i++) begin
          nxt_res[32*i +: 32] = nar_bits[i];
          nxt_fl = fflags_t'(nxt_fl | nar_fl[i]);
        end
      end
      OP_SC_WIDEN: begin
        nxt_res[63:0] = wid_bits[0];
        nxt_fl        = wid_fl[0];
      end
      default: begin
        nxt_res[31:0] = nar_bits[0];
        nxt_fl        = nar_fl[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      fl_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        fl_q   <= nxt_fl;
      end
    end
  end

  assign flg_inexact   = fl_q.nx;
  assign flg_overflow  = fl_q.of;
  assign flg_underflow = fl_q.uf;
  assign flg_invalid   = fl_q.nv;

  p_pk_narrow_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_e == OP_PK_NARROW |=> result[VEC_W-1:HALF] == '0);

  p_sc_widen_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_e == OP_SC_WIDEN |=> result[VEC_W-1:64] == $past(old_dst[VEC_W-1:64]));

  p_sc_narrow_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_e == OP_SC_NARROW |=> result[VEC_W-1:32] == $past(old_dst[VEC_W-1:32]));

  p_widen_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_narrow |=> !flg_inexact && !flg_overflow && !flg_underflow);

  p_ovf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> flg_inexact);

  p_uf_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flg_underflow |-> flg_inexact);

  p_valid_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(fl_q));

endmodule

// File: tb/fp_prec_conv_bench.sv
module fp_prec_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [1:0]   rmode = 2'b00;
  logic [127:0] src = '0;
  logic [127:0] old_dst = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         flg_inexact, flg_overflow, flg_underflow, flg_invalid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_prec_conv u_fp_prec_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rmode(rmode),
    .src(src), .old_dst(old_dst), .out_valid(out_valid), .result(result),
    .flg_inexact(flg_inexact), .flg_overflow(flg_overflow),
    .flg_underflow(flg_underflow), .flg_invalid(flg_invalid)
  );

  function automatic logic [63:0] rnd64();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // exact value of a non-negative single encoding (exp 255, frac 0 counts as 2^128)
  function automatic real spval(input logic [31:0] p);
    real fr;
    int  e;
    fr = p[22:0];
    e  = int'(p[30:23]);
    if (e == 0) return fr * (2.0 ** (-149));
    return (fr + 8388608.0) * (2.0 ** (e - 150));
  endfunction

  function automatic logic [63:0] ref_widen(input logic [31:0] x, output logic nv);
    real v;
    nv = 1'b0;
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] == '0) return {x[31], 11'h7FF, 52'h0};
      nv = !x[22];
      return {x[31], 11'h7FF, 1'b1, x[21:0], 29'h0};
    end
    if (x[30:0] == '0) return {x[31], 63'h0};
    v = spval({1'b0, x[30:0]});
    if (x[31]) v = -v;
    return $realtobits(v);
  endfunction

  function automatic logic [31:0] ref_narrow(input logic [63:0] d, input logic [1:0] rm,
                                             output logic [3:0] f);
    real ax, d1, d2;
    logic [31:0] lo, hi, mid, t;
    logic s, up, tinf;
    s = d[63];
    f = 4'b0;                              // {nv, of, uf, nx}
    tinf = (rm == 2'b00) || (rm == 2'b01 && s) || (rm == 2'b10 && !s);
    if (d[62:52] == 11'h7FF) begin
      if (d[51:0] == '0) return {s, 8'hFF, 23'h0};
      f[3] = !d[51];
      return {s, 8'hFF, 1'b1, d[50:29]};
    end
    ax = $bitstoreal({1'b0, d[62:0]});
    if (ax == 0.0) return {s, 31'h0};
    lo = 32'h0;
    hi = 32'h7F800000;
    while (lo < hi) begin
      mid = lo + (hi - lo + 32'd1) / 32'd2;
      if (spval(mid) <= ax) lo = mid;
      else hi = mid - 32'd1;
    end
    t = lo;
    if (t == 32'h7F800000) begin
      f[2] = 1'b1;
      f[0] = 1'b1;
      return tinf ? {s, 8'hFF, 23'h0} : {s, 8'hFE, 23'h7FFFFF};
    end
    if (spval(t) == ax) return {s, t[30:0]};
    f[0] = 1'b1;
    case (rm)
      2'b00: begin
        d1 = ax - spval(t);
        d2 = spval(t + 32'd1) - ax;
        up = (d1 > d2) || (d1 == d2 && t[0]);
      end
      2'b01:   up = s;
      2'b10:   up = !s;
      default: up = 1'b0;
    endcase
    if (up) t = t + 32'd1;
    if (t == 32'h7F800000) f[2] = 1'b1;
    if (ax < 2.0 ** (-126)) f[1] = 1'b1;
    return {s, t[30:0]};
  endfunction

  task automatic model(input logic [1:0] o, input logic [1:0] rm, input logic [127:0] s,
                       input logic [127:0] od, output logic [127:0] r, output logic [3:0] f);
    logic       nv;
    logic [3:0] lf;
    f = 4'b0;
    r = od;
    case (o)
      2'b00: for (int i = 0; i < 2; i++) begin
        r[64*i +: 64] = ref_widen(s[32*i +: 32], nv);
        f[3] = f[3] | nv;
      end
      2'b01: begin
        r = '0;
        for (int i = 0; i < 2; i++) begin
          r[32*i +: 32] = ref_narrow(s[64*i +: 64], rm, lf);
          f = f | lf;
        end
      end
      2'b10: begin
        r[63:0] = ref_widen(s[31:0], nv);
        f[3] = nv;
      end
      default: begin
        r[31:0] = ref_narrow(s[63:0], rm, lf);
        f = lf;
      end
    endcase
  endtask

  task automatic chk128(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s flags{nv,of,uf,nx} act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] rm, input logic [127:0] s,
                       input logic [127:0] od, input string tres, input string tfl);
    logic [127:0] er;
    logic [3:0]   ef;
    @(negedge clk);
    op = o; rmode = rm; src = s; old_dst = od; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(o, rm, s, od, er, ef);
    chk4("R11 valid", {3'b0, out_valid}, 4'b0001);
    chk128(tres, result, er);
    chk4(tfl, {flg_invalid, flg_overflow, flg_underflow, flg_inexact}, ef);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000 / CLK_PERIOD) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] dv;
    logic [127:0] keep;
    logic [10:0] exps [8];
    exps[0] = 11'd1023; exps[1] = 11'd1150; exps[2] = 11'd897; exps[3] = 11'd896;
    exps[4] = 11'd893;  exps[5] = 11'd874;  exps[6] = 11'd873; exps[7] = 11'd872;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk128("R11 reset", result, '0);
    chk4("R11 reset", {flg_invalid, flg_overflow, flg_underflow, flg_inexact, out_valid} == 5'b0 ? 4'b0 : 4'b1, 4'b0);
    rst_n = 1'b1;

    // R1 / R3 basic widening
    apply(2'b00, 2'b00, {64'h0, 32'hC0490FDB, 32'h3F800000}, '1, "R1", "R1 flags");
    apply(2'b10, 2'b00, {96'h0, 32'h42F60000}, {64'hDEADBEEFCAFEF00D, 64'h1}, "R3", "R3 flags");
    // R6: subnormal singles
    apply(2'b00, 2'b00, {64'h0, 32'h80000001, 32'h007FFFFF}, '0, "R6", "R6 flags");
    apply(2'b10, 2'b11, {96'h0, 32'h00400000}, {64'hFFFF0000FFFF0000, 64'h0}, "R6 scalar", "R6 flags");
    // R7: NaNs both directions
    apply(2'b00, 2'b00, {64'h0, 32'hFFC00123, 32'h7FA00001}, '0, "R7 widen", "R7 invalid");
    apply(2'b10, 2'b00, {96'h0, 32'h7FC00001}, '0, "R7 quiet", "R7 no invalid");
    apply(2'b01, 2'b00, {64'hFFF8000123400000, 64'h7FF4000000000123}, '0, "R7 narrow", "R7 invalid");
    // R2 / R4 basic narrowing
    apply(2'b01, 2'b00, {64'h400921FB54442D18, 64'hBFF0000000000000}, '1, "R2", "R2 flags");
    apply(2'b11, 2'b00, {64'h7FF0000000000001, 64'h3FB999999999999A}, {96'hA5A5A5A5_5A5A5A5A_12345678, 32'h0},
          "R4", "R10 scalar ignores upper lane");

    // R8 and R9: overflow and tiny boundaries, every mode and sign
    for (int m = 0; m < 4; m++) begin
      for (int sg = 0; sg < 2; sg++) begin
        apply(2'b01, 2'(m), {1'(sg), 63'h47F0000000000000, 1'(sg), 63'h7FEFFFFFFFFFFFFF}, '0, "R8", "R8 flags");
        apply(2'b11, 2'(m), {64'h0, 1'(sg), 63'h47EFFFFFF0000000}, '0, "R8 carry", "R8 flags");
        apply(2'b01, 2'(m), {1'(sg), 63'h36A0000000000000, 1'(sg), 63'h3690000000000000}, '0, "R9", "R9 flags");
        apply(2'b01, 2'(m), {1'(sg), 63'h0000000000000001, 1'(sg), 63'h3818000000000000}, '0, "R9 tiny", "R9 flags");
      end
    end

    // R5: sweep lowest kept, guard and sticky bits over boundary exponents
    for (int ei = 0; ei < 8; ei++) begin
      for (int m = 0; m < 4; m++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int c = 0; c < 16; c++) begin
            for (int st = 0; st < 2; st++) begin
              dv = {1'(sg), exps[ei], 20'hA5A5A, 4'(c), 27'h0, 1'(st)};
              apply(2'b01, 2'(m), {~dv[63], dv[62:0], dv}, '0, "R5", "R5 flags");
            end
          end
        end
      end
    end

    // R10 and R1-R4: mixed random vectors
    for (int n = 0; n < 3000; n++) begin
      logic [127:0] s, od;
      logic [1:0] o, rm;
      s  = {rnd64(), rnd64()};
      od = {rnd64(), rnd64()};
      o  = 2'(rnd64());
      rm = 2'(rnd64());
      if (n % 3 == 1) begin
        s[126:116] = 11'(850 + (rnd64() % 320));
        s[62:52]   = 11'(850 + (rnd64() % 320));
      end
      if (n % 3 == 2) begin
        s[30:23] = 8'(rnd64() % 3);
        s[62:55] = 8'(rnd64() % 3);
      end
      case (o)
        2'b00:   apply(o, rm, s, od, "R1", "R10");
        2'b01:   apply(o, rm, s, od, "R2", "R10");
        2'b10:   apply(o, rm, s, od, "R3", "R10");
        default: apply(o, rm, s, od, "R4", "R10");
      endcase
    end

    // R11: outputs hold while the strobe is low
    apply(2'b01, 2'b00, {64'h3FF0000000000001, 64'hC000000000000000}, '0, "R11 pre-hold", "R11 flags");
    keep = result;
    @(negedge clk);
    op = 2'b00; src = '1; old_dst = '1;
    @(negedge clk);
    chk128("R11 hold", result, keep);
    chk4("R11 hold valid", {3'b0, out_valid}, 4'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule